// File: doc/BRIEF.md
# Dual Converter Mode and Calibration Sequencer

This block is the digital control for a pair of sigma-delta converters: a primary and an auxiliary. Both are governed by one 8-bit mode register that holds an enable bit for each converter and a shared 3-bit operating code. The block decodes that register into power-down and idle levels and one-cycle reset pulses for each converter. It runs single and continuous conversions and four calibration kinds. For each converter it produces result-load and calibration-load strobes, plus ready and error status flags. When a one-shot operation (a single conversion or a calibration) has finished on every enabled converter, the block writes the operating code back to power-down by itself.

The reset rules favour the primary side. A mode-register write, or a primary configuration write while the primary is enabled, restarts both converters. An auxiliary configuration write restarts only the auxiliary. In that case, if the primary is producing results, the auxiliary drops its own completions until the primary has delivered one, so that its output instants follow the primary's. If an auxiliary calibration completes while the temperature sensor is its input, the ready flag is still set, but no calibration load occurs and the error flag is raised.

Index 0 of every 2-bit port is the primary converter and index 1 is the auxiliary.

Top module: `adc_mode_seq`

## Requirements
- R1: After reset the mode register reads 00h. Every status flag, strobe and reset pulse is low, and both converters are in power-down. Register bits 7, 6 and 3 always read 0.
- R2: Register layout: bit 5 enables the primary, bit 4 enables the auxiliary, and bits 2..0 hold the code. Code 000 is power-down, 001 idle, 010 single, 011 continuous, 100/101 internal zero/full-scale calibration, and 110/111 system zero/full-scale calibration. `cvt_pd[i]` is high when converter i is disabled or the code is 000. `cvt_idle[i]` is high when converter i is enabled and the code is 001.
- R3: Every mode-register write pulses `cvt_rst` = 2'b11 in the next cycle, even when the value written equals the stored value. The write also clears both ready flags and the error flag.
- R4: A primary configuration write (`cfg_wr[0]`) resets both converters when the primary is enabled, and has no effect when it is disabled.
- R5: An auxiliary configuration write (`cfg_wr[1]`) with no primary-side reset in the same cycle pulses only `cvt_rst[1]` and clears only the auxiliary ready flag. Primary completions keep loading results.
- R6: After an auxiliary-only reset taken while the primary is running, auxiliary completions are dropped. Acceptance resumes in the cycle after the first primary completion. If the primary is not running at the time of the reset, no completion is dropped.
- R7: In single mode, each enabled converter's first completion pulses its `res_ld` and sets its ready flag in the next cycle. When all enabled converters have completed, the code reads 000 in that same cycle.
- R8: In continuous mode, every completion of an enabled converter pulses `res_ld` and sets ready, and the code is unchanged.
- R9: While the code has bit 2 set, `rate_max` is high. A calibration completion pulses `cal_ld` (subject to R10) and sets ready. `cal_fs` equals bit 0 of the last code written. The code returns to 000 as in R7.
- R10: An auxiliary calibration that completes while `temp_sel` is high sets ready and the error flag, and produces no `cal_ld[1]`.
- R11: `rdy_clr[i]` clears ready flag i in the next cycle. A completion in the same cycle takes precedence and leaves the flag set.
- R12: Completions arriving in power-down or idle, on a disabled converter, or after a one-shot operation has already completed produce no strobe and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| mode_rdata | output | 8 | Mode register read value |
| cfg_wr | input | 2 | Configuration write strobes, [0] primary, [1] auxiliary |
| temp_sel | input | 1 | Auxiliary input is the temperature sensor |
| cvt_done | input | 2 | Conversion-complete pulses from each converter |
| rdy_clr | input | 2 | Software clear of the ready flags |
| cvt_rst | output | 2 | One-cycle converter reset pulses |
| cvt_pd | output | 2 | Power-down level per converter |
| cvt_idle | output | 2 | Idle (filter and modulator held) level per converter |
| res_ld | output | 2 | Result register load strobes |
| cal_ld | output | 2 | Calibration register load strobes |
| cal_fs | output | 1 | Calibration kind: 1 full-scale, 0 zero-scale |
| rate_max | output | 1 | Forces the filter rate to its maximum |
| rdy | output | 2 | Ready flags |
| err | output | 2 | Error flags ([0] is always 0) |

## Verification
The hardest case to reach is the auxiliary re-alignment. It needs a continuous primary that is already producing results, then an auxiliary-only restart. After that, the auxiliary and primary completions must be placed on the same cycle and on later cycles. The bench builds this state with a continuous write to both converters followed by an auxiliary configuration strobe. It then checks that an auxiliary completion coinciding with the releasing primary completion is still dropped, while the next one loads. A sweep over all 256 register values covers the decode and auto-return rules. A loop over every one-shot code, every enable pair and both temperature-select values covers the completion and error paths.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int REG_W = 8;
    localparam int NCH   = 2;

    typedef enum logic [2:0] {
        MD_PDOWN  = 3'b000,
        MD_IDLE   = 3'b001,
        MD_SINGLE = 3'b010,
        MD_CONT   = 3'b011,
        MD_ZS_INT = 3'b100,
        MD_FS_INT = 3'b101,
        MD_ZS_SYS = 3'b110,
        MD_FS_SYS = 3'b111
    } md_e;

    typedef struct packed {
        logic [REG_W-1:0] mreg;
        logic             cal_fs;
        logic [NCH-1:0]   rst;
    } top_st_t;

    typedef struct packed {
        logic pend;
        logic rdy;
        logic err;
        logic wait_sync;
        logic res_ld;
        logic cal_ld;
    } ch_st_t;
endpackage

// File: rtl/adc_chan_ctl.sv
module adc_chan_ctl
    import adc_seq_pkg::*;
#(
    parameter bit IS_AUX = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  md_e  md,
    input  logic chan_rst,
    input  logic pend_ld,
    input  logic pend_val,
    input  logic sync_req,
    input  logic pri_run,
    input  logic pri_done,
    input  logic done,
    input  logic temp_sel,
    input  logic rdy_clr,
    output logic res_ld,
    output logic cal_ld,
    output logic rdy,
    output logic err,
    output logic pend,
    output logic pend_nxt
);
    ch_st_t q, d;
    logic   is_cal, one_shot, accept;

    always_comb begin
        d        = q;
        d.res_ld = 1'b0;
        d.cal_ld = 1'b0;
        is_cal   = md[2];
        one_shot = (md == MD_SINGLE) || is_cal;
        accept   = done && en && !chan_rst && !q.wait_sync &&
                   ((md == MD_CONT) || (one_shot && q.pend));

        // release the phase hold on the first primary output
        if (q.wait_sync && (pri_done || !pri_run))
            d.wait_sync = 1'b0;

        if (rdy_clr)
            d.rdy = 1'b0;

        if (accept) begin
            d.rdy = 1'b1;
            if (is_cal) begin
                if (IS_AUX && temp_sel)
                    d.err = 1'b1;
                else
                    d.cal_ld = 1'b1;
            end else begin
                d.res_ld = 1'b1;
            end
            if (one_shot)
                d.pend = 1'b0;
        end

        if (chan_rst) begin
            d.rdy       = 1'b0;
            d.err       = 1'b0;
            d.wait_sync = IS_AUX ? sync_req : 1'b0;
            if (pend_ld)
                d.pend = pend_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_ld   = q.res_ld;
    assign cal_ld   = q.cal_ld;
    assign rdy      = q.rdy;
    assign err      = q.err;
    assign pend     = q.pend;
    assign pend_nxt = d.pend;
endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
    import adc_seq_pkg::*;
#(
    parameter int PRI_EN_BIT = 5,
    parameter int AUX_EN_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [REG_W-1:0] mode_wdata,
    output logic [REG_W-1:0] mode_rdata,
    input  logic [NCH-1:0]   cfg_wr,
    input  logic             temp_sel,
    input  logic [NCH-1:0]   cvt_done,
    input  logic [NCH-1:0]   rdy_clr,
    output logic [NCH-1:0]   cvt_rst,
    output logic [NCH-1:0]   cvt_pd,
    output logic [NCH-1:0]   cvt_idle,
    output logic [NCH-1:0]   res_ld,
    output logic [NCH-1:0]   cal_ld,
    output logic             cal_fs,
    output logic             rate_max,
    output logic [NCH-1:0]   rdy,
    output logic [NCH-1:0]   err
);
    localparam logic [REG_W-1:0] WR_MASK =
        REG_W'((1 << PRI_EN_BIT) | (1 << AUX_EN_BIT) | 7);

    top_st_t          q, d;
    logic [REG_W-1:0] wd;
    md_e              md_q, md_w;
    logic [NCH-1:0]   en_q, en_w, chan_rst, pend_val, sync_req, pend_q, pend_nxt;
    logic             rst_both, rst_aux, pri_run;

    always_comb begin
        wd       = mode_wdata & WR_MASK;
        md_q     = md_e'(q.mreg[2:0]);
        md_w     = md_e'(wd[2:0]);
        en_q     = {q.mreg[AUX_EN_BIT], q.mreg[PRI_EN_BIT]};
        en_w     = {wd[AUX_EN_BIT], wd[PRI_EN_BIT]};
        rst_both = mode_wr || (cfg_wr[0] && en_q[0]);
        rst_aux  = !rst_both && cfg_wr[1];
        chan_rst = {rst_both || rst_aux, rst_both};
        pri_run  = en_q[0] &&
                   ((md_q == MD_CONT) || ((md_q == MD_SINGLE) && pend_q[0]));
        sync_req = {rst_aux && pri_run, 1'b0};
        for (int i = 0; i < NCH; i++)
            pend_val[i] = en_w[i] && ((md_w == MD_SINGLE) || md_w[2]);

        d     = q;
        d.rst = chan_rst;
        if (mode_wr) begin
            d.mreg   = wd;
            d.cal_fs = wd[0];
        end else if (((md_q == MD_SINGLE) || md_q[2]) && (pend_nxt == '0)) begin
            d.mreg[2:0] = MD_PDOWN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        adc_chan_ctl #(.IS_AUX(gi == 1)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_q[gi]),
            .md       (md_q),
            .chan_rst (chan_rst[gi]),
            .pend_ld  (mode_wr),
            .pend_val (pend_val[gi]),
            .sync_req (sync_req[gi]),
            .pri_run  (pri_run),
            .pri_done (cvt_done[0]),
            .done     (cvt_done[gi]),
            .temp_sel (temp_sel),
            .rdy_clr  (rdy_clr[gi]),
            .res_ld   (res_ld[gi]),
            .cal_ld   (cal_ld[gi]),
            .rdy      (rdy[gi]),
            .err      (err[gi]),
            .pend     (pend_q[gi]),
            .pend_nxt (pend_nxt[gi])
        );
        assign cvt_pd[gi]   = !en_q[gi] || (md_q == MD_PDOWN);
        assign cvt_idle[gi] = en_q[gi] && (md_q == MD_IDLE);
    end

    assign mode_rdata = q.mreg;
    assign cvt_rst    = q.rst;
    assign cal_fs     = q.cal_fs;
    assign rate_max   = md_q[2];
endmodule

// File: rtl/adc_mode_seq_chk.sv
module adc_mode_seq_chk
    import adc_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic [REG_W-1:0] mode_rdata,
    input logic [NCH-1:0]   cfg_wr,
    input logic [NCH-1:0]   cvt_done,
    input logic [NCH-1:0]   cvt_rst,
    input logic [NCH-1:0]   cvt_pd,
    input logic [NCH-1:0]   cvt_idle,
    input logic [NCH-1:0]   res_ld,
    input logic [NCH-1:0]   cal_ld,
    input logic [NCH-1:0]   rdy,
    input logic [NCH-1:0]   err
);
    assert_wr_resets_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (cvt_rst == 2'b11));

    assert_wr_clears_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (rdy == 2'b00) && (err == 2'b00));

    assert_aux_only_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr[1] && !mode_wr && !(cfg_wr[0] && mode_rdata[5])) |=> (cvt_rst == 2'b10));

    assert_pri_cfg_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr == 2'b01 && !mode_wr && !mode_rdata[5]) |=> (cvt_rst == 2'b00));

    assert_load_sets_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((res_ld | cal_ld) & ~rdy) == 2'b00);

    assert_failed_cal_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_ld[1] && err[1]) && !err[0]);

    assert_pd_idle_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cvt_pd[0], cvt_idle[0]}) && $onehot0({cvt_pd[1], cvt_idle[1]}));

    assert_no_load_in_pd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cvt_done[0] && cvt_pd[0] && !mode_wr) |=> !res_ld[0] && !cal_ld[0]);
endmodule

bind adc_mode_seq adc_mode_seq_chk u_chk (.*);

// File: tb/tb_adc_mode_seq.sv
module tb_adc_mode_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_rdata;
    logic [1:0] cfg_wr = '0;
    logic       temp_sel = 1'b0;
    logic [1:0] cvt_done = '0;
    logic [1:0] rdy_clr = '0;
    logic [1:0] cvt_rst, cvt_pd, cvt_idle, res_ld, cal_ld, rdy, err;
    logic       cal_fs, rate_max;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    adc_mode_seq dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [7:0] v);
        mode_wdata = v; mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic done_pulse(input logic [1:0] v);
        cvt_done = v;
        @(negedge clk);
        cvt_done = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", mode_rdata, 0);
        chk("R1 pd", cvt_pd, 3);
        chk("R1 flags", {rdy, err, res_ld, cal_ld, cvt_rst}, 0);

        // R1 R2 R3 sweep of every register value, no completions
        for (int v = 0; v < 256; v++) begin
            logic [2:0] m;
            logic       ep, ea, oneshot;
            m  = v[2:0]; ep = v[5]; ea = v[4];
            oneshot = (m == 3'd2) || m[2];
            wr_mode(8'(v));
            chk("R3 rst both", cvt_rst, 3);
            chk("R3 rdy cleared", rdy, 0);
            chk("R1 readback", mode_rdata, v & 8'h37);
            chk("R2 pd", cvt_pd, {!ea || m == 0, !ep || m == 0});
            chk("R2 idle", cvt_idle, {ea && m == 1, ep && m == 1});
            chk("R9 rate_max", rate_max, m[2]);
            @(negedge clk);
            chk("R3 rst one cycle", cvt_rst, 0);
            chk("R7 auto return", mode_rdata[2:0], (oneshot && !(ep || ea)) ? 0 : m);
        end

        // R7 R9 R10 one-shot codes, enable pairs, temp select
        for (int c = 0; c < 5; c++) begin
            for (int e = 1; e < 4; e++) begin
                for (int t = 0; t < 2; t++) begin
                    logic [2:0] m;
                    logic       ep, ea, cal;
                    m   = (c == 0) ? 3'd2 : 3'(c + 3);
                    ep  = e[0]; ea = e[1]; cal = m[2];
                    temp_sel = t[0];
                    wr_mode({2'b00, ep, ea, 1'b0, m});
                    @(negedge clk);
                    done_pulse(2'b01);
                    chk("R7 R9 pri load", {cal_ld[0], res_ld[0]}, ep ? (cal ? 2 : 1) : 0);
                    chk("R7 pri rdy", rdy[0], ep);
                    chk("R7 code after pri", mode_rdata[2:0], ea ? m : 0);
                    if (ep && cal) chk("R9 cal_fs", cal_fs, m[0]);
                    done_pulse(2'b10);
                    chk("R7 R9 R10 aux load", {cal_ld[1], res_ld[1]},
                        ea ? (cal ? (t ? 0 : 2) : 1) : 0);
                    chk("R10 aux err", err[1], ea && cal && t);
                    chk("R7 aux rdy", rdy[1], ea);
                    chk("R7 code final", mode_rdata[2:0], 0);
                    done_pulse(2'b11);
                    chk("R12 after one-shot", {res_ld, cal_ld}, 0);
                end
            end
        end
        temp_sel = 1'b0;

        // R8 continuous, both enabled
        wr_mode(8'h33);
        for (int k = 0; k < 3; k++) begin
            done_pulse(2'b11);
            chk("R8 res_ld", res_ld, 3);
            chk("R8 rdy", rdy, 3);
            chk("R8 code kept", mode_rdata, 8'h33);
        end
        // R11 clear and set precedence
        rdy_clr = 2'b01; @(negedge clk); rdy_clr = '0;
        chk("R11 clear", rdy, 2'b10);
        rdy_clr = 2'b01; cvt_done = 2'b01; @(negedge clk); rdy_clr = '0; cvt_done = '0;
        chk("R11 set wins", rdy, 2'b11);

        // R5 R6 auxiliary-only restart while primary runs
        cfg_wr = 2'b10; @(negedge clk); cfg_wr = '0;
        chk("R5 aux only rst", cvt_rst, 2'b10);
        chk("R5 aux rdy cleared", rdy, 2'b01);
        done_pulse(2'b10);
        chk("R6 aux dropped", res_ld, 0);
        done_pulse(2'b11);
        chk("R6 coincident aux dropped", res_ld, 2'b01);
        done_pulse(2'b10);
        chk("R6 aux accepted", res_ld, 2'b10);
        chk("R6 aux rdy", rdy[1], 1);

        // R4 primary configuration write
        cfg_wr = 2'b01; @(negedge clk); cfg_wr = '0;
        chk("R4 pri cfg enabled", cvt_rst, 3);
        wr_mode(8'h13);
        done_pulse(2'b10);
        cfg_wr = 2'b01; @(negedge clk); cfg_wr = '0;
        chk("R4 pri cfg disabled", cvt_rst, 0);
        chk("R4 aux rdy kept", rdy[1], 1);
        // R6 no hold when primary is not running
        cfg_wr = 2'b10; @(negedge clk); cfg_wr = '0;
        done_pulse(2'b10);
        chk("R6 no hold", res_ld, 2'b10);

        // R12 idle, disabled, power-down
        wr_mode(8'h31);
        done_pulse(2'b11);
        chk("R12 idle", {res_ld, rdy}, 0);
        wr_mode(8'h03);
        done_pulse(2'b11);
        chk("R12 disabled", {res_ld, rdy}, 0);
        chk("R2 disabled pd", cvt_pd, 3);
        wr_mode(8'h30);
        done_pulse(2'b11);
        chk("R12 pdown", {res_ld, cal_ld, rdy}, 0);

        finish_run();
    end
endmodule